// File: doc/BRIEF.md
# Condition-Code Integer ALU

This block is the integer execution slice of a processor that keeps a four-bit condition-code register. Each cycle it may receive one decoded operation. The supported operations are add, add-with-carry, bit clear, bit set, bit test, exclusive OR, compare and clear. Each operation comes with an operand size of byte, word or longword and two operands. The block returns the sized result and a write enable for the destination. It also returns the flag values that the operation would produce, and loads those flags into its own flag register on the clock edge.

Every operation has its own rule for the flags. Adds derive all four flags from the sum. The logical operations clear V and keep C. Compare produces signed and unsigned orderings and writes no result. Bit test also writes no result and changes only the flags. Clear forces Z and keeps C. An overflow pulse goes to a trap handler outside the block. Operand fetch, memory locking and exception entry are the job of the surrounding pipeline.

Top module: `cc_int_alu`

## Requirements
- R1: An active-low asynchronous reset clears the flag register. flags_o is 4'b0000 while rst_ni is low and after it is released.
- R2: For add (op 3'd0) the result is the low-order bits of src_a_i + src_b_i at the selected size. Operand bits above that size are ignored, and result bits above it read zero.
- R3: For add and add-with-carry, the flags are encoded as {N,Z,V,C} on bits [3:0]. N is the result sign bit and Z is set when the result is zero. V is set when both inputs have the same sign and the result has the other sign. C is the carry out of the most significant bit of the selected size. ovf_o equals V for these two operations and is 0 for every other operation.
- R4: Add-with-carry (op 3'd1) adds the current C flag, src_a_i and src_b_i in a single addition. The C it uses is the one held in the flag register.
- R5: Bit clear (op 3'd2) gives src_b_i AND NOT src_a_i, bit set (op 3'd3) gives src_b_i OR src_a_i, and exclusive OR (op 3'd5) gives src_b_i XOR src_a_i. All three assert wr_en_o.
- R6: Bit clear, bit set, bit test and exclusive OR take N and Z from their sized result, set V to 0 and leave C unchanged.
- R7: Bit test (op 3'd4) sets the flags from src_a_i AND src_b_i. It keeps wr_en_o low and drives result_o to zero.
- R8: Compare (op 3'd6) keeps wr_en_o low and result_o zero. It sets N when src_a_i < src_b_i as signed values, Z when they are equal, V to 0, and C when src_a_i < src_b_i as unsigned values. All comparisons use the selected size.
- R9: Clear (op 3'd7) writes a zero result with wr_en_o high, sets N=0, Z=1 and V=0, and leaves C unchanged.
- R10: The flag register loads flags_next_o on a clock edge only when valid_i is high; otherwise it holds. While valid_i is low, wr_en_o and ovf_o are 0 and flags_next_o equals flags_o.
- R11: size_i selects the operand size: 2'd0 is byte (8 bits), 2'd1 is word (16 bits), and 2'd2 and 2'd3 are both longword (32 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Decoded operation code |
| size_i | input | 2 | Operand size code |
| src_a_i | input | 32 | Addend, mask or first compare source |
| src_b_i | input | 32 | Sum, data or second compare source |
| result_o | output | 32 | Sized result, zero above the selected size |
| wr_en_o | output | 1 | Destination write enable |
| flags_next_o | output | 4 | Flags this operation produces, {N,Z,V,C} |
| flags_o | output | 4 | Flag register, {N,Z,V,C} |
| ovf_o | output | 1 | Signed overflow indication for the trap handler |

## Verification
Two functions meet in one cycle when a flag load and an add-with-carry happen together. An add-with-carry can issue in the cycle right after an add that produced a carry. It must then use the C bit written at that same edge, not an older copy. The bench provokes this in two ways. A word add with carry out is followed at once by a word add-with-carry on 0x7FFF. A longword add-with-carry is placed directly behind a bit set that kept C=1. The expected sum and overflow are computed with the new carry included.

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned LONG_W = 32;
  localparam int unsigned OP_W   = 3;
  localparam int unsigned SZ_W   = 2;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_BCLR = 3'd2,
    OP_BSET = 3'd3,
    OP_BTST = 3'd4,
    OP_XOR  = 3'd5,
    OP_CMP  = 3'd6,
    OP_CLR  = 3'd7
  } alu_op_e;

  typedef enum logic [SZ_W-1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LALT = 2'd3
  } alu_size_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } alu_flags_t;
endpackage

// File: rtl/cc_alu_size_sel.sv
module cc_alu_size_sel
  import cc_alu_pkg::*;
#(
  parameter int unsigned DW = LONG_W
) (
  input  alu_size_e     size_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] msb_sel_o,
  output logic [DW:0]   carry_sel_o,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] b_o
);
  logic [DW:0] one_hot;
  logic [DW:0] mask_full;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: one_hot = (DW+1)'(1) << BYTE_W;
      SZ_WORD: one_hot = (DW+1)'(1) << WORD_W;
      default: one_hot = (DW+1)'(1) << LONG_W;
    endcase
  end

  assign mask_full   = one_hot - (DW+1)'(1);
  assign mask_o      = mask_full[DW-1:0];
  assign carry_sel_o = one_hot;
  assign msb_sel_o   = one_hot[DW:1];
  assign a_o         = a_i & mask_o;
  assign b_o         = b_i & mask_o;
endmodule

// File: rtl/cc_alu_adder.sv
module cc_alu_adder #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic [DW-1:0] mask_i,
  input  logic [DW-1:0] msb_sel_i,
  input  logic [DW:0]   carry_sel_i,
  output logic [DW-1:0] sum_o,
  output logic          cout_o,
  output logic          ovf_o
);
  logic [DW:0] sum_full;
  logic        sa, sb, sr;

  // single adder: carry-in folded into the same sum
  assign sum_full = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin_i};
  assign sum_o    = sum_full[DW-1:0] & mask_i;
  assign cout_o   = |(sum_full & carry_sel_i);
  assign sa       = |(a_i & msb_sel_i);
  assign sb       = |(b_i & msb_sel_i);
  assign sr       = |(sum_o & msb_sel_i);
  assign ovf_o    = (sa == sb) && (sr != sa);
endmodule

// File: rtl/cc_alu_cmp.sv
module cc_alu_cmp #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] msb_sel_i,
  output logic          eq_o,
  output logic          slt_o,
  output logic          ult_o
);
  logic sa, sb;

  assign sa    = |(a_i & msb_sel_i);
  assign sb    = |(b_i & msb_sel_i);
  assign eq_o  = (a_i == b_i);
  assign ult_o = (a_i < b_i);
  // differing signs decide directly, else unsigned order holds
  assign slt_o = (sa != sb) ? sa : ult_o;
endmodule

// File: rtl/cc_alu_logic.sv
module cc_alu_logic
  import cc_alu_pkg::*;
#(
  parameter int unsigned DW = LONG_W
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] mask_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_BCLR: res_o = data_i & ~mask_i;
      OP_BSET: res_o = data_i | mask_i;
      OP_XOR:  res_o = data_i ^ mask_i;
      default: res_o = data_i & mask_i;
    endcase
  end
endmodule

// File: rtl/cc_int_alu.sv
module cc_int_alu
  import cc_alu_pkg::*;
#(
  parameter int unsigned DW = LONG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [2:0]    op_i,
  input  logic [1:0]    size_i,
  input  logic [DW-1:0] src_a_i,
  input  logic [DW-1:0] src_b_i,
  output logic [DW-1:0] result_o,
  output logic          wr_en_o,
  output logic [3:0]    flags_next_o,
  output logic [3:0]    flags_o,
  output logic          ovf_o
);
  alu_op_e    op;
  alu_size_e  sz;
  alu_flags_t flags_q, flags_d;

  logic [DW-1:0] mask, msb_sel, a_m, b_m;
  logic [DW:0]   carry_sel;
  logic [DW-1:0] add_res, log_res;
  logic          add_c, add_v;
  logic          cmp_eq, cmp_slt, cmp_ult;
  logic          cin;

  assign op  = alu_op_e'(op_i);
  assign sz  = alu_size_e'(size_i);
  assign cin = (op == OP_ADDC) & flags_q.c;

  cc_alu_size_sel #(.DW(DW)) u_size (
    .size_i     (sz),
    .a_i        (src_a_i),
    .b_i        (src_b_i),
    .mask_o     (mask),
    .msb_sel_o  (msb_sel),
    .carry_sel_o(carry_sel),
    .a_o        (a_m),
    .b_o        (b_m)
  );

  cc_alu_adder #(.DW(DW)) u_add (
    .a_i        (a_m),
    .b_i        (b_m),
    .cin_i      (cin),
    .mask_i     (mask),
    .msb_sel_i  (msb_sel),
    .carry_sel_i(carry_sel),
    .sum_o      (add_res),
    .cout_o     (add_c),
    .ovf_o      (add_v)
  );

  cc_alu_cmp #(.DW(DW)) u_cmp (
    .a_i      (a_m),
    .b_i      (b_m),
    .msb_sel_i(msb_sel),
    .eq_o     (cmp_eq),
    .slt_o    (cmp_slt),
    .ult_o    (cmp_ult)
  );

  cc_alu_logic #(.DW(DW)) u_log (
    .op_i  (op),
    .mask_i(a_m),
    .data_i(b_m),
    .res_o (log_res)
  );

  always_comb begin
    result_o = '0;
    wr_en_o  = 1'b0;
    ovf_o    = 1'b0;
    flags_d  = flags_q;
    if (valid_i) begin
      unique case (op)
        OP_ADD, OP_ADDC: begin
          result_o = add_res;
          wr_en_o  = 1'b1;
          ovf_o    = add_v;
          flags_d  = '{n: |(add_res & msb_sel), z: add_res == '0, v: add_v, c: add_c};
        end
        OP_BCLR, OP_BSET, OP_XOR: begin
          result_o = log_res;
          wr_en_o  = 1'b1;
          flags_d  = '{n: |(log_res & msb_sel), z: log_res == '0, v: 1'b0, c: flags_q.c};
        end
        OP_BTST: begin
          flags_d  = '{n: |(log_res & msb_sel), z: log_res == '0, v: 1'b0, c: flags_q.c};
        end
        OP_CMP: begin
          flags_d  = '{n: cmp_slt, z: cmp_eq, v: 1'b0, c: cmp_ult};
        end
        default: begin
          wr_en_o  = 1'b1;
          flags_d  = '{n: 1'b0, z: 1'b1, v: 1'b0, c: flags_q.c};
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flags_q <= '0;
    else if (valid_i) flags_q <= flags_d;
  end

  assign flags_next_o = flags_d;
  assign flags_o      = flags_q;
endmodule

// File: rtl/cc_alu_chk.sv
module cc_alu_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [2:0]  op_i,
  input logic [1:0]  size_i,
  input logic [31:0] result_o,
  input logic        wr_en_o,
  input logic [3:0]  flags_next_o,
  input logic [3:0]  flags_o,
  input logic        ovf_o
);
  logic [31:0] upper;
  logic        is_logic;

  always_comb begin
    case (size_i)
      2'd0:    upper = 32'hFFFF_FF00;
      2'd1:    upper = 32'hFFFF_0000;
      default: upper = 32'h0000_0000;
    endcase
  end
  assign is_logic = (op_i == 3'd2) || (op_i == 3'd3) || (op_i == 3'd4) || (op_i == 3'd5);

  AST_RESET_CLEAR: assert property (@(posedge clk_i) !rst_ni |-> flags_o == 4'b0000); // R1
  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_o & upper) == 32'h0); // R2
  AST_OVF_TRACKS_V: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (valid_i && op_i <= 3'd1 && flags_next_o[1])); // R3
  AST_LOGIC_KEEP_C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_logic) |=> (flags_o[1] == 1'b0 && flags_o[0] == $past(flags_o[0]))); // R6
  AST_TEST_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd4) |-> (!wr_en_o && result_o == 32'h0)); // R7
  AST_CMP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd6) |-> (!wr_en_o && result_o == 32'h0 && !flags_next_o[1])); // R8
  AST_CLR_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd7) |=> (flags_o[3:1] == 3'b010 && flags_o[0] == $past(flags_o[0]))); // R9
  AST_CLR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd7) |-> (wr_en_o && result_o == 32'h0)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(flags_o)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!wr_en_o && !ovf_o && flags_next_o == flags_o)); // R10
  AST_FLAG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> flags_o == $past(flags_next_o)); // R10
endmodule

bind cc_int_alu cc_alu_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .op_i        (op_i),
  .size_i      (size_i),
  .result_o    (result_o),
  .wr_en_o     (wr_en_o),
  .flags_next_o(flags_next_o),
  .flags_o     (flags_o),
  .ovf_o       (ovf_o)
);

// File: tb/cc_int_alu_tb_top.sv
module cc_int_alu_tb_top;
  localparam int CLK_P = 10;
  localparam int NV    = 16;

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  sz;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic        wr;
    logic [3:0]  fl;
    logic        ovf;
  } vec_t;

  // ops: 0 add,1 addc,2 bclr,3 bset,4 btst,5 xor,6 cmp,7 clr; sizes 0 B,1 W,2/3 L (R11)
  // flags {N,Z,V,C}; each row depends on the C left by the row before
  localparam vec_t VEC [NV] = '{
    '{3'd0, 2'd0, 32'h0000007F, 32'h00000001, 32'h00000080, 1'b1, 4'hA, 1'b1},
    '{3'd0, 2'd0, 32'hFFFFFF80, 32'h00000080, 32'h00000000, 1'b1, 4'h7, 1'b1},
    '{3'd3, 2'd1, 32'h000000F0, 32'h00008001, 32'h000080F1, 1'b1, 4'h9, 1'b0},
    '{3'd1, 2'd2, 32'hFFFFFFFF, 32'h00000000, 32'h00000000, 1'b1, 4'h5, 1'b0},
    '{3'd2, 2'd2, 32'hFFFF0000, 32'h12345678, 32'h00005678, 1'b1, 4'h1, 1'b0},
    '{3'd5, 2'd1, 32'h000000FF, 32'h000000FF, 32'h00000000, 1'b1, 4'h5, 1'b0},
    '{3'd4, 2'd0, 32'h00000080, 32'h000000F0, 32'h00000000, 1'b0, 4'h9, 1'b0},
    '{3'd6, 2'd1, 32'h00008000, 32'h00000001, 32'h00000000, 1'b0, 4'h8, 1'b0},
    '{3'd6, 2'd2, 32'h00000001, 32'hFFFFFFFF, 32'h00000000, 1'b0, 4'h1, 1'b0},
    '{3'd7, 2'd2, 32'hDEADBEEF, 32'hCAFEF00D, 32'h00000000, 1'b1, 4'h5, 1'b0},
    '{3'd6, 2'd0, 32'h0000AA55, 32'h00000055, 32'h00000000, 1'b0, 4'h4, 1'b0},
    '{3'd1, 2'd1, 32'h00007FFF, 32'h00000000, 32'h00007FFF, 1'b1, 4'h0, 1'b0},
    '{3'd0, 2'd1, 32'h0000FFFF, 32'h00000001, 32'h00000000, 1'b1, 4'h5, 1'b0},
    '{3'd1, 2'd1, 32'h00007FFF, 32'h00000000, 32'h00008000, 1'b1, 4'hA, 1'b1},
    '{3'd0, 2'd3, 32'h00010000, 32'h00010000, 32'h00020000, 1'b1, 4'h0, 1'b0},
    '{3'd0, 2'd2, 32'h80000000, 32'h80000000, 32'h00000000, 1'b1, 4'h7, 1'b1}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] src_a_i = '0;
  logic [31:0] src_b_i = '0;
  logic [31:0] result_o;
  logic        wr_en_o;
  logic [3:0]  flags_next_o;
  logic [3:0]  flags_o;
  logic        ovf_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  cc_int_alu dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .size_i(size_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .result_o(result_o), .wr_en_o(wr_en_o),
    .flags_next_o(flags_next_o), .flags_o(flags_o), .ovf_o(ovf_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] op, input logic [1:0] sz);
    if (sz == 2'd3) return "R11 R2 R3";
    case (op)
      3'd0:    return "R2 R3";
      3'd1:    return "R4 R3";
      3'd4:    return "R7 R6";
      3'd6:    return "R8";
      3'd7:    return "R9";
      default: return "R5 R6";
    endcase
  endfunction

  initial begin
    #(CLK_P*5000);
    errors++;
    $display("FAIL R10 watchdog act=%0d exp=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    chk("R1 reset flags", 32'(flags_o), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 flags after release", 32'(flags_o), 32'h0);
    chk("R10 idle wr_en", 32'(wr_en_o), 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      valid_i = 1'b1;
      op_i = VEC[i].op; size_i = VEC[i].sz;
      src_a_i = VEC[i].a; src_b_i = VEC[i].b;
      #1;
      chk({tag_of(VEC[i].op, VEC[i].sz), " result"}, result_o, VEC[i].res);
      chk({tag_of(VEC[i].op, VEC[i].sz), " wr_en"}, 32'(wr_en_o), 32'(VEC[i].wr));
      chk({tag_of(VEC[i].op, VEC[i].sz), " flags_next"}, 32'(flags_next_o), 32'(VEC[i].fl));
      chk("R3 ovf", 32'(ovf_o), 32'(VEC[i].ovf));
      @(posedge clk_i);
      #1;
      chk("R10 flag load", 32'(flags_o), 32'(VEC[i].fl));
    end

    // R10: strobe low, an overflowing add must touch nothing
    @(negedge clk_i);
    valid_i = 1'b0; op_i = 3'd0; size_i = 2'd0;
    src_a_i = 32'h7F; src_b_i = 32'h7F;
    #1;
    chk("R10 idle wr_en", 32'(wr_en_o), 32'h0);
    chk("R10 idle ovf", 32'(ovf_o), 32'h0);
    chk("R10 idle flags_next", 32'(flags_next_o), 32'h7);
    @(posedge clk_i); #1;
    chk("R10 idle hold", 32'(flags_o), 32'h7);

    // R1: asynchronous reset between edges
    @(negedge clk_i);
    #2 rst_ni = 1'b0;
    #1;
    chk("R1 async reset", 32'(flags_o), 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R4: addc right after reset uses C=0
    valid_i = 1'b1; op_i = 3'd1; size_i = 2'd0;
    src_a_i = 32'hFF; src_b_i = 32'h00;
    #1;
    chk("R4 addc cin zero", result_o, 32'h000000FF);
    @(negedge clk_i);
    valid_i = 1'b0;
    @(negedge clk_i);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule